// File: doc/BRIEF.md
# Nine-Bit Serial Display Command Transmitter

This block sends display-controller commands over a three-wire serial link that has no separate data/command pin. Each byte goes out as a nine-bit word. The leading bit of the word tells the panel how to treat the byte: 0 marks a command and 1 marks a parameter or pixel byte. The eight payload bits follow, most significant bit first. The clock idles low, data changes on the falling edge and the panel samples on the rising edge.

A host starts a transaction with a single-cycle `start` strobe. The strobe carries the command byte, a unit count and two mode flags.
- With `pixelMode` set, each unit is a 16-bit pixel sent as two words, high byte first. Otherwise each unit is one parameter byte.
- With `packedMode` set, the link is framed for a receiver whose shift register only handles bytes, so eight words fill nine bytes:
  - The command gets a block of its own, with seven all-zero no-op words ahead of it.
  - The data goes out in blocks of eight words, and a short last block is filled up with all-zero words.
  - Chip select is released between blocks.

The host presents parameter data on `dataIn`. The block pulses `dataTake` once it has captured a unit, and the host then moves on to the next unit. Transactions marked as reads are refused with an error pulse.

Top module: `spi9_cmd_tx`

## Requirements
- R1: Every word is 9 clock periods long. The flag bit goes first, followed by the 8 payload bits, most significant bit first.
- R2: The flag bit is 0 for the command word and for padding words, and 1 for every parameter or pixel byte.
- R3: In unpacked mode, chip select stays low from the first bit of the command word to the last bit of the final parameter word. It is released after that, and `busy` low always implies chip select high.
- R4: In pixel mode, `paramCount` counts 16-bit pixels. Each pixel is sent as two data words: `dataIn[15:8]` first, then `dataIn[7:0]`. In byte mode only `dataIn[7:0]` is sent.
- R5: In packed mode the command is sent in a 72-bit frame of its own, made of seven all-zero words followed by the command word.
- R6: In packed mode, data words are sent in 72-bit frames of 8 words, with chip select released between frames. A short final frame is filled with all-zero words. When the word count is an exact multiple of 8, no extra frame is sent.
- R7: A `start` with `readCmd` high produces a one-cycle `errFlag` pulse in the next cycle. No chip select activity follows, and `busy` stays low.
- R8: The clock idles low while chip select is high, and `mosi` never changes while `sclk` is high.
- R9: Every high phase of `sclk` lasts exactly `HALF_CYCLES` system clocks.
- R10: A `start` pulse while `busy` is high has no effect on the serial output.
- R11: `dataTake` pulses exactly once per consumed unit (a byte, or a pixel after its low byte), and only while `busy`.
- R12: During and right after reset, `csN` is 1, `sclk` is 0, and `busy` and `errFlag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (taken only while idle) |
| cmdByte | input | 8 | Command byte |
| paramCount | input | CNT_W | Number of parameter bytes or pixels |
| pixelMode | input | 1 | Units are 16-bit pixels, high byte first |
| packedMode | input | 1 | Use nine-byte block framing with zero padding |
| readCmd | input | 1 | Transaction is a read; refused |
| dataIn | input | 16 | Current parameter byte (low half) or pixel |
| dataTake | output | 1 | Current `dataIn` unit has been captured |
| busy | output | 1 | Transaction in progress |
| errFlag | output | 1 | One-cycle pulse when a read is refused |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| csN | output | 1 | Active-low chip select |

## Verification
`errFlag` rises one cycle after the `start` edge, and `busy` rises at that same edge. `dataTake` pulses in the cycle after the word holding the unit's last byte is loaded. Each `sclk` high phase ends after exactly `HALF_CYCLES` clocks, and two words are separated by two system clocks plus a low half-period.

The bench does not predict absolute bit times. Instead, it samples on the falling clock edge, records `mosi` whenever it sees an `sclk` rising transition while selected, and closes a frame when chip select rises. It polls `busy` to find the end of a transaction and then compares the captured frames, lengths and bits with a stream built from the requirements. High-phase widths and `mosi` changes under a high clock are counted continuously.

// File: rtl/spi9_pkg.sv
package spi9_pkg;

  localparam int WORD_W      = 9;
  localparam int BYTE_W      = 8;
  localparam int PIX_W       = 16;
  localparam int BLOCK_WORDS = 8;

  typedef enum logic [2:0] {
    SEL_NOP  = 3'd0,
    SEL_CMD  = 3'd1,
    SEL_BYTE = 3'd2,
    SEL_HI   = 3'd3,
    SEL_LO   = 3'd4
  } wordSel_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } ctrlState_t;

  typedef struct packed {
    logic     load;
    wordSel_t sel;
    logic     csOn;
    logic     csOff;
  } strobe_t;

endpackage

// File: rtl/spi9_ctrl.sv
module spi9_ctrl
  import spi9_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [BYTE_W-1:0] cmdByte,
  input  logic [CNT_W-1:0]  paramCount,
  input  logic              pixelMode,
  input  logic              packedMode,
  input  logic              readCmd,
  input  logic              wordDone,
  output strobe_t           stb,
  output logic [BYTE_W-1:0] cmdLatched,
  output logic              dataTake,
  output logic              errFlag,
  output logic              busy
);

  localparam int SLOT_W = $clog2(BLOCK_WORDS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(BLOCK_WORDS - 1);

  ctrlState_t        state;
  logic              inData;
  logic [SLOT_W-1:0] slot;
  logic              hiPhase;
  logic [CNT_W-1:0]  remain;
  logic              pixR;
  logic              packR;
  logic              lastR;
  logic [BYTE_W-1:0] cmdR;
  logic              takeQ;
  logic              errQ;

  logic              wasData;
  logic              consume;
  logic [CNT_W-1:0]  remainNext;

  always_comb begin
    wasData    = inData && (remain != '0);
    consume    = wasData && (!pixR || !hiPhase);
    remainNext = remain - CNT_W'(consume);
  end

  always_comb begin
    stb       = '0;
    stb.sel   = SEL_NOP;
    if (state == ST_LOAD) begin
      stb.load = 1'b1;
      stb.csOn = 1'b1;
      if (!inData) begin
        stb.sel = (packR && slot != LAST_SLOT) ? SEL_NOP : SEL_CMD;
      end else if (remain == '0) begin
        stb.sel = SEL_NOP;
      end else if (pixR) begin
        stb.sel = hiPhase ? SEL_HI : SEL_LO;
      end else begin
        stb.sel = SEL_BYTE;
      end
    end
    if (state == ST_SHIFT && wordDone) begin
      if (!inData) begin
        stb.csOff = !(packR && slot != LAST_SLOT) && (packR || remain == '0);
      end else if (packR) begin
        stb.csOff = (slot == LAST_SLOT);
      end else begin
        stb.csOff = (remainNext == '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      inData  <= 1'b0;
      slot    <= '0;
      hiPhase <= 1'b1;
      remain  <= '0;
      pixR    <= 1'b0;
      packR   <= 1'b0;
      lastR   <= 1'b0;
      cmdR    <= '0;
      takeQ   <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      takeQ <= 1'b0;
      errQ  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (readCmd) begin
              errQ <= 1'b1;
            end else begin
              cmdR    <= cmdByte;
              remain  <= paramCount;
              pixR    <= pixelMode;
              packR   <= packedMode;
              inData  <= 1'b0;
              slot    <= '0;
              hiPhase <= 1'b1;
              lastR   <= 1'b0;
              state   <= ST_LOAD;
            end
          end
        end
        ST_LOAD: begin
          takeQ <= inData && (remain != '0) && (!pixR || !hiPhase);
          state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (wordDone) begin
            if (!inData) begin
              if (packR && slot != LAST_SLOT) begin
                slot  <= slot + 1'b1;
                state <= ST_LOAD;
              end else begin
                slot <= '0;
                if (remain == '0) begin
                  lastR <= 1'b1;
                  state <= ST_GAP;
                end else begin
                  inData <= 1'b1;
                  lastR  <= 1'b0;
                  state  <= packR ? ST_GAP : ST_LOAD;
                end
              end
            end else begin
              remain <= remainNext;
              if (wasData && pixR) begin
                hiPhase <= !hiPhase;
              end
              if (packR) begin
                if (slot == LAST_SLOT) begin
                  slot  <= '0;
                  lastR <= (remainNext == '0);
                  state <= ST_GAP;
                end else begin
                  slot  <= slot + 1'b1;
                  state <= ST_LOAD;
                end
              end else if (remainNext == '0) begin
                lastR <= 1'b1;
                state <= ST_GAP;
              end else begin
                state <= ST_LOAD;
              end
            end
          end
        end
        default: begin
          state <= lastR ? ST_IDLE : ST_LOAD;
        end
      endcase
    end
  end

  assign cmdLatched = cmdR;
  assign dataTake   = takeQ;
  assign errFlag    = errQ;
  assign busy       = (state != ST_IDLE);

endmodule

// File: rtl/spi9_shift.sv
module spi9_shift
  import spi9_pkg::*;
#(
  parameter int HALF_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BYTE_W-1:0] cmdByte,
  input  logic [PIX_W-1:0]  dataIn,
  output logic              sclk,
  output logic              mosi,
  output logic              csN,
  output logic              wordDone
);

  localparam int HC_W  = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [HC_W-1:0]  HC_LAST  = HC_W'(HALF_CYCLES - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] nextWord;
  logic [BIT_W-1:0]  bitCnt;
  logic [HC_W-1:0]   halfCnt;
  logic              active;
  logic              sclkR;
  logic              csR;
  logic              doneR;

  always_comb begin
    case (stb.sel)
      SEL_CMD:  nextWord = {1'b0, cmdByte};
      SEL_BYTE: nextWord = {1'b1, dataIn[BYTE_W-1:0]};
      SEL_HI:   nextWord = {1'b1, dataIn[PIX_W-1:BYTE_W]};
      SEL_LO:   nextWord = {1'b1, dataIn[BYTE_W-1:0]};
      default:  nextWord = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      halfCnt  <= '0;
      active   <= 1'b0;
      sclkR    <= 1'b0;
      doneR    <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (stb.load) begin
        shiftReg <= nextWord;
        bitCnt   <= '0;
        halfCnt  <= '0;
        sclkR    <= 1'b0;
        active   <= 1'b1;
      end else if (active) begin
        if (halfCnt == HC_LAST) begin
          halfCnt <= '0;
          if (!sclkR) begin
            sclkR <= 1'b1;
          end else begin
            sclkR <= 1'b0;
            if (bitCnt == BIT_LAST) begin
              active <= 1'b0;
              doneR  <= 1'b1;
            end else begin
              bitCnt   <= bitCnt + 1'b1;
              shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
            end
          end
        end else begin
          halfCnt <= halfCnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csR <= 1'b1;
    end else if (stb.csOn) begin
      csR <= 1'b0;
    end else if (stb.csOff) begin
      csR <= 1'b1;
    end
  end

  assign sclk     = sclkR;
  assign mosi     = shiftReg[WORD_W-1];
  assign csN      = csR;
  assign wordDone = doneR;

endmodule

// File: rtl/spi9_cmd_tx.sv
module spi9_cmd_tx
  import spi9_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int HALF_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [7:0]       cmdByte,
  input  logic [CNT_W-1:0] paramCount,
  input  logic             pixelMode,
  input  logic             packedMode,
  input  logic             readCmd,
  input  logic [15:0]      dataIn,
  output logic             dataTake,
  output logic             busy,
  output logic             errFlag,
  output logic             sclk,
  output logic             mosi,
  output logic             csN
);

  strobe_t           stb;
  logic              wordDone;
  logic [BYTE_W-1:0] cmdLatched;

  spi9_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .cmdByte    (cmdByte),
    .paramCount (paramCount),
    .pixelMode  (pixelMode),
    .packedMode (packedMode),
    .readCmd    (readCmd),
    .wordDone   (wordDone),
    .stb        (stb),
    .cmdLatched (cmdLatched),
    .dataTake   (dataTake),
    .errFlag    (errFlag),
    .busy       (busy)
  );

  spi9_shift #(.HALF_CYCLES(HALF_CYCLES)) u_shift (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .cmdByte  (cmdLatched),
    .dataIn   (dataIn),
    .sclk     (sclk),
    .mosi     (mosi),
    .csN      (csN),
    .wordDone (wordDone)
  );

endmodule

// File: rtl/spi9_cmd_tx_chk.sv
module spi9_cmd_tx_chk #(
  parameter int HALF_CYCLES = 2
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic readCmd,
  input logic busy,
  input logic errFlag,
  input logic dataTake,
  input logic sclk,
  input logic mosi,
  input logic csN
);

  logic [15:0] hiLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiLen <= '0;
    end else if (sclk) begin
      hiLen <= hiLen + 1'b1;
    end else begin
      hiLen <= '0;
    end
  end

  // R8
  mosi_stable_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R8
  idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  // R9
  high_phase_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclk) |-> (hiLen == 16'(HALF_CYCLES)));

  // R7
  err_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> $past(start && readCmd && !busy));

  // R3
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csN);

  // R11
  take_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataTake |-> busy);

endmodule

bind spi9_cmd_tx spi9_cmd_tx_chk #(.HALF_CYCLES(HALF_CYCLES)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .readCmd  (readCmd),
  .busy     (busy),
  .errFlag  (errFlag),
  .dataTake (dataTake),
  .sclk     (sclk),
  .mosi     (mosi),
  .csN      (csN)
);

// File: tb/tb_spi9_cmd_tx.sv
`timescale 1ns/1ps
module tb_spi9_cmd_tx;

  localparam int CNT_W = 8;
  localparam int HALF  = 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [7:0]       cmdByte = '0;
  logic [CNT_W-1:0] paramCount = '0;
  logic             pixelMode = 1'b0;
  logic             packedMode = 1'b0;
  logic             readCmd = 1'b0;
  logic [15:0]      dataIn;
  logic             dataTake, busy, errFlag, sclk, mosi, csN;

  always #4 clk = ~clk;

  spi9_cmd_tx #(.CNT_W(CNT_W), .HALF_CYCLES(HALF)) dut (
    .clk(clk), .rstN(rstN), .start(start), .cmdByte(cmdByte),
    .paramCount(paramCount), .pixelMode(pixelMode), .packedMode(packedMode),
    .readCmd(readCmd), .dataIn(dataIn), .dataTake(dataTake), .busy(busy),
    .errFlag(errFlag), .sclk(sclk), .mosi(mosi), .csN(csN)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // data source driven from a take counter
  logic [15:0] srcMem [0:15];
  int takeCnt = 0;
  int takeBase = 0;
  assign dataIn = srcMem[(takeCnt - takeBase) & 15];

  // serial monitor
  logic bitBuf [0:4095];
  int   bitCount = 0;
  int   frameEnd [0:255];
  int   frameCount = 0;
  int   hiRun = 0;
  int   hiBad = 0;
  int   modeViol = 0;
  logic prevSclk = 1'b0;
  logic prevCs = 1'b1;
  logic prevMosi = 1'b0;

  always @(negedge clk) begin
    if (dataTake) takeCnt <= takeCnt + 1;
    if (rstN) begin
      if (!csN && sclk && !prevSclk) begin
        bitBuf[bitCount & 4095] = mosi;
        bitCount = bitCount + 1;
      end
      if (csN && !prevCs) begin
        frameEnd[frameCount & 255] = bitCount;
        frameCount = frameCount + 1;
      end
      if (sclk && prevSclk && (mosi != prevMosi)) modeViol = modeViol + 1;
      if (sclk) hiRun = hiRun + 1;
      else begin
        if (prevSclk && hiRun != HALF) hiBad = hiBad + 1;
        hiRun = 0;
      end
    end
    prevSclk = sclk;
    prevCs   = csN;
    prevMosi = mosi;
  end

  // expected stream
  logic expBits [0:1023];
  int   expN;
  int   expEnd [0:31];
  int   expFrames;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pushWord(input logic flag, input logic [7:0] b);
    expBits[expN] = flag;
    expN++;
    for (int i = 7; i >= 0; i--) begin
      expBits[expN] = b[i];
      expN++;
    end
  endtask

  task automatic closeFrame();
    expEnd[expFrames] = expN;
    expFrames++;
  endtask

  task automatic buildExpected(input logic [7:0] cmd, input int cnt,
                               input bit pix, input bit pack);
    logic [8:0] words [0:63];
    int nw = 0;
    expN = 0;
    expFrames = 0;
    for (int u = 0; u < cnt; u++) begin
      if (pix) begin
        words[nw] = {1'b1, srcMem[u][15:8]}; nw++;
        words[nw] = {1'b1, srcMem[u][7:0]};  nw++;
      end else begin
        words[nw] = {1'b1, srcMem[u][7:0]};  nw++;
      end
    end
    if (!pack) begin
      pushWord(1'b0, cmd);
      for (int w = 0; w < nw; w++) pushWord(words[w][8], words[w][7:0]);
      closeFrame();
    end else begin
      for (int k = 0; k < 7; k++) pushWord(1'b0, 8'h00);
      pushWord(1'b0, cmd);
      closeFrame();
      for (int w = 0; w < ((nw + 7) / 8) * 8; w++) begin
        if (w < nw) pushWord(words[w][8], words[w][7:0]);
        else pushWord(1'b0, 8'h00);
        if ((w % 8) == 7) closeFrame();
      end
    end
  endtask

  task automatic runTxn(input logic [7:0] cmd, input int cnt, input bit pix,
                        input bit pack, input string tag);
    int bitBase, frameBase, tb0, firstBad;
    bitBase   = bitCount;
    frameBase = frameCount;
    takeBase  = takeCnt;
    tb0       = takeCnt;
    @(negedge clk);
    cmdByte = cmd; paramCount = CNT_W'(cnt); pixelMode = pix;
    packedMode = pack; readCmd = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    buildExpected(cmd, cnt, pix, pack);
    check(frameCount - frameBase == expFrames, {tag, " frame count"},
          frameCount - frameBase, expFrames);
    for (int f = 0; f < expFrames && f < frameCount - frameBase; f++)
      check(frameEnd[(frameBase + f) & 255] - bitBase == expEnd[f],
            {tag, " frame end"}, frameEnd[(frameBase + f) & 255] - bitBase, expEnd[f]);
    check(bitCount - bitBase == expN, {tag, " bit count"}, bitCount - bitBase, expN);
    firstBad = -1;
    for (int i = 0; i < expN && i < bitCount - bitBase; i++)
      if (firstBad < 0 && bitBuf[(bitBase + i) & 4095] !== expBits[i]) firstBad = i;
    check(firstBad < 0, {tag, " bit stream first mismatch index"}, firstBad, -1);
    check(takeCnt - tb0 == cnt, {"R11 ", tag, " take pulses"}, takeCnt - tb0, cnt);
  endtask

  task automatic testReset();
    check(csN === 1'b1, "R12 csN in reset", csN, 1);
    check(sclk === 1'b0, "R12 sclk in reset", sclk, 0);
    check(busy === 1'b0 && errFlag === 1'b0, "R12 busy/errFlag in reset", busy, 0);
  endtask

  task automatic testRead();
    int fb;
    fb = frameCount;
    @(negedge clk);
    cmdByte = 8'h0A; paramCount = 1; readCmd = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; readCmd = 1'b0;
    check(errFlag === 1'b1, "R7 errFlag one cycle after start", errFlag, 1);
    check(busy === 1'b0, "R7 busy stays low on read", busy, 0);
    @(negedge clk);
    check(errFlag === 1'b0, "R7 errFlag is a single pulse", errFlag, 0);
    repeat (20) @(negedge clk);
    check(csN === 1'b1 && frameCount == fb, "R7 no chip select activity", frameCount - fb, 0);
  endtask

  task automatic testBusyStart();
    int bitBase, frameBase, firstBad;
    bitBase = bitCount; frameBase = frameCount; takeBase = takeCnt;
    @(negedge clk);
    cmdByte = 8'h3C; paramCount = 1; pixelMode = 0; packedMode = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    cmdByte = 8'hFF; paramCount = 3; packedMode = 1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (30) @(negedge clk);
    buildExpected(8'h3C, 1, 0, 0);
    check(frameCount - frameBase == 1, "R10 start while busy adds no frame",
          frameCount - frameBase, 1);
    firstBad = -1;
    for (int i = 0; i < expN; i++)
      if (firstBad < 0 && bitBuf[(bitBase + i) & 4095] !== expBits[i]) firstBad = i;
    check(firstBad < 0 && bitCount - bitBase == expN, "R10 original stream intact",
          bitCount - bitBase, expN);
    packedMode = 0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) srcMem[i] = 16'hA500 ^ (16'(i) * 16'h1357);
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    runTxn(8'h29, 0, 0, 0, "R1 R2 R3 unpacked command only");
    runTxn(8'h36, 3, 0, 0, "R2 R3 unpacked with parameters");
    runTxn(8'h2C, 3, 1, 0, "R4 unpacked pixels");
    runTxn(8'h11, 0, 0, 1, "R5 packed command only");
    runTxn(8'hB1, 5, 0, 1, "R6 packed padded block");
    runTxn(8'hE0, 8, 0, 1, "R6 packed exact block");
    runTxn(8'h2C, 5, 1, 1, "R6 R4 packed pixels");
    testRead();
    testBusyStart();
    check(modeViol == 0, "R8 mosi changed while sclk high", modeViol, 0);
    check(hiBad == 0, "R9 sclk high phase length", hiBad, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule